// File: doc/BRIEF.md
# Platform-Level Interrupt Controller

This block gathers level-sensitive interrupt lines from up to 31 global sources and presents one interrupt request per target context, two contexts by default. Each source passes through a gateway that latches a request as pending and then refuses further requests from that line until software signals that the source has been serviced. For each context, an arbiter looks at every source that is pending and enabled for that context. It raises the context's request when the best such source has a priority strictly above the context's threshold.

Software reaches the block through a simple 32-bit register port. Reads are combinational and writes are taken on the clock edge. Through this port software sets the per-source priorities, the per-context enable words and the per-context thresholds. Reading a context's claim register returns the winning source and takes it out of the pending set. Writing that source number back to the same register completes the service, and the gateway may then accept a new request from the line.

Top module: `plic_top`

## Requirements
- R1: After reset every priority, enable bit and threshold reads as 0, every claim register returns 0, and every `ctx_irq` bit is low.
- R2: The priority of source n is at byte offset 4*n. Only the low 3 bits are stored and the upper bits read as 0. Offset 0, which would belong to source 0, always reads 0.
- R3: The enable word of context c is at 0x2000 + 0x80*c. Bit n enables source n. Bit 0 reads 0 and cannot be set.
- R4: The threshold of context c is at 0x200000 + 0x1000*c and is 3 bits wide. The claim/complete register of context c is at 0x200000 + 0x1000*c + 4.
- R5: `ctx_irq[c]` is high exactly when at least one source is pending, enabled for c, and has a priority strictly greater than the threshold of c. A priority of 0 never raises a request.
- R6: A claim read returns the eligible source with the highest priority. On equal priority the smaller source number wins. The read returns 0 when no source is eligible.
- R7: A claim read that returns a non-zero source clears that source's pending state. Until that source is completed, its gateway ignores its input line.
- R8: Writing a claimed source's number to the claim register completes it. If the line is still high, the source becomes pending again one cycle later.
- R9: A completion write is ignored when the value is 0, when it is above the number of sources, or when the source is not enabled for the context that is written.
- R10: Reads of unmapped addresses return 0, and writes to them change no state.
- R11: The contexts are arbitrated independently. A claim from one context removes the source from every context's pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_irq | input | NUM_SRC | Level interrupt lines; bit n is source n (index 1..NUM_SRC) |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe; a claim read takes its side effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address and current state |
| ctx_irq | output | NUM_CTX | Interrupt request per context |

## Verification
A register write takes effect at the edge that samples it. Read data, and any `ctx_irq` change that follows from the new configuration, can therefore be observed in the next cycle. A rise on a source line is registered by its gateway one edge later, so the bench lets one edge pass before it looks at `ctx_irq` or issues a claim. A completion likewise re-arms the pending state only at the edge after the write. The scoreboard compares claim and register reads at the falling edge inside the read cycle, where the data is combinational from the state and is the same value the claim removes at the next rising edge.

// File: rtl/plic_pkg.sv
package plic_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned EN_BASE    = 32'h0000_2000;
    localparam int unsigned EN_STRIDE  = 32'h0000_0080;
    localparam int unsigned CTX_BASE   = 32'h0020_0000;
    localparam int unsigned CTX_STRIDE = 32'h0000_1000;
    localparam int unsigned CLAIM_OFF  = 32'h0000_0004;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pend_o,
    output logic busy_o
);
    typedef struct packed {
        logic pend;
        logic busy;
    } gw_t;

    gw_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (complete_i) begin
            st_d.busy = 1'b0;
        end
        if (claim_i) begin
            st_d.pend = 1'b0;
            st_d.busy = 1'b1;
        end else if (line_i && !st_q.busy && !st_q.pend) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign busy_o = st_q.busy;
endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
    parameter int unsigned NUM_SRC = 31,
    parameter int unsigned PRIO_W  = 3,
    localparam int unsigned ID_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC:1]             pend_i,
    input  logic [NUM_SRC:1]             en_i,
    input  logic [NUM_SRC:1][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]            thr_i,
    output logic [ID_W-1:0]              win_id_o,
    output logic                         req_o
);
    logic [PRIO_W-1:0] best_p;
    logic [ID_W-1:0]   best_id;

    // Ascending scan with strict compare: ties keep the smaller ID,
    // and starting from the threshold enforces "strictly above".
    always_comb begin
        best_p  = thr_i;
        best_id = '0;
        for (int n = 1; n <= NUM_SRC; n++) begin
            if (pend_i[n] && en_i[n] && (prio_i[n] > best_p)) begin
                best_p  = prio_i[n];
                best_id = ID_W'(n);
            end
        end
    end

    assign win_id_o = best_id;
    assign req_o    = (best_id != '0);
endmodule

// File: rtl/plic_top.sv
module plic_top #(
    parameter int unsigned NUM_SRC = 31,
    parameter int unsigned NUM_CTX = 2,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned ADDR_W  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC:1]     src_irq,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CTX-1:0]   ctx_irq
);
    import plic_pkg::*;

    localparam int unsigned ID_W       = $clog2(NUM_SRC + 1);
    localparam int unsigned PRIO_IDX_W = $clog2(NUM_SRC + 1);

    typedef struct packed {
        logic [NUM_SRC:1][PRIO_W-1:0]  prio;
        logic [NUM_CTX-1:0][NUM_SRC:1] en;
        logic [NUM_CTX-1:0][PRIO_W-1:0] thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [NUM_SRC:1] pend_q;
    logic [NUM_SRC:1] busy_q;
    logic [NUM_SRC:1] claim_vec;
    logic [NUM_SRC:1] cmpl_vec;
    logic [ID_W-1:0]  arb_id [NUM_CTX];

    logic                  prio_win;
    logic [PRIO_IDX_W-1:0] prio_idx;

    assign prio_win = ((bus_addr >> (PRIO_IDX_W + 2)) == '0) && (bus_addr[1:0] == 2'b00);
    assign prio_idx = bus_addr[PRIO_IDX_W+1:2];

    always_comb begin
        cfg_d     = cfg_q;
        bus_rdata = '0;
        claim_vec = '0;
        cmpl_vec  = '0;

        if (prio_win) begin
            for (int n = 1; n <= NUM_SRC; n++) begin
                if (prio_idx == PRIO_IDX_W'(n)) begin
                    bus_rdata = 32'(cfg_q.prio[n]);
                    if (bus_wr) begin
                        cfg_d.prio[n] = bus_wdata[PRIO_W-1:0];
                    end
                end
            end
        end

        for (int c = 0; c < NUM_CTX; c++) begin
            if (bus_addr == ADDR_W'(EN_BASE + EN_STRIDE * c)) begin
                bus_rdata = 32'({cfg_q.en[c], 1'b0});
                if (bus_wr) begin
                    cfg_d.en[c] = bus_wdata[NUM_SRC:1];
                end
            end
            if (bus_addr == ADDR_W'(CTX_BASE + CTX_STRIDE * c)) begin
                bus_rdata = 32'(cfg_q.thr[c]);
                if (bus_wr) begin
                    cfg_d.thr[c] = bus_wdata[PRIO_W-1:0];
                end
            end
            if (bus_addr == ADDR_W'(CTX_BASE + CTX_STRIDE * c + CLAIM_OFF)) begin
                bus_rdata = 32'(arb_id[c]);
                for (int n = 1; n <= NUM_SRC; n++) begin
                    if (bus_rd && (arb_id[c] == ID_W'(n))) begin
                        claim_vec[n] = 1'b1;
                    end
                    if (bus_wr && (bus_wdata == 32'(n)) && cfg_q.en[c][n]) begin
                        cmpl_vec[n] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_gw
        plic_gateway u_gw (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_i     (src_irq[s]),
            .claim_i    (claim_vec[s]),
            .complete_i (cmpl_vec[s]),
            .pend_o     (pend_q[s]),
            .busy_o     (busy_q[s])
        );
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_arb
        plic_arbiter #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W)
        ) u_arb (
            .pend_i   (pend_q),
            .en_i     (cfg_q.en[c]),
            .prio_i   (cfg_q.prio),
            .thr_i    (cfg_q.thr[c]),
            .win_id_o (arb_id[c]),
            .req_o    (ctx_irq[c])
        );
    end
endmodule

// File: rtl/plic_checker.sv
module plic_checker #(
    parameter int unsigned NUM_SRC = 31,
    parameter int unsigned NUM_CTX = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CTX-1:0]   ctx_irq,
    input logic [NUM_SRC:1]     pend_q,
    input logic [NUM_SRC:1]     busy_q,
    input logic [NUM_SRC:1]     claim_vec,
    input logic [NUM_SRC:1]     cmpl_vec
);
    // R7: a claimed source is no longer pending on the following cycle
    a_r7_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_vec != '0) |=> ((pend_q & $past(claim_vec)) == '0));

    // R7: a claimed source is held off until completion
    a_r7_claim_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_vec != '0) |=> ((busy_q & $past(claim_vec)) == $past(claim_vec)));

    // R7: a source is never pending and outstanding at once
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & busy_q) == '0));

    // R8: completion frees the gateway
    a_r8_complete_frees: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmpl_vec & ~claim_vec) != '0) |=> ((busy_q & $past(cmpl_vec & ~claim_vec)) == '0));

    // R5: a request needs some pending source
    a_r5_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_irq != '0) |-> (pend_q != '0));

    // R6: only a pending source can be claimed
    a_r6_claim_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((claim_vec & ~pend_q) == '0));
endmodule

bind plic_top plic_checker #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_chk (.*);

// File: tb/plic_top_test.sv
module plic_top_test;
    localparam int unsigned NS = 31;
    localparam int unsigned NC = 2;
    localparam int unsigned AW = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS:1]     src_irq = '0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NC-1:0]   ctx_irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    plic_top uut (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ctx_irq(ctx_irq)
    );

    function automatic logic [AW-1:0] a_prio(int n); return AW'(4 * n); endfunction
    function automatic logic [AW-1:0] a_en(int c); return AW'(32'h2000 + 32'h80 * c); endfunction
    function automatic logic [AW-1:0] a_thr(int c); return AW'(32'h200000 + 32'h1000 * c); endfunction
    function automatic logic [AW-1:0] a_clm(int c); return AW'(32'h200004 + 32'h1000 * c); endfunction

    // Monitor: compares read data in the middle of each read cycle
    always @(negedge clk) begin
        if (bus_rd && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (bus_rdata !== it.exp) begin
                bad++;
                $display("FAIL %s: rdata actual=%0h expected=%0h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] e, string tag);
        item_t it;
        @(posedge clk); #1;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(int c, logic e, string tag);
        @(negedge clk);
        total++;
        if (ctx_irq[c] !== e) begin
            bad++;
            $display("FAIL %s: ctx_irq[%0d] actual=%0b expected=%0b", tag, c, ctx_irq[c], e);
        end
    endtask

    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(a_prio(1), 0, "R1 prio reset");
        rd(a_en(1), 0, "R1 enable reset");
        rd(a_thr(0), 0, "R1 threshold reset");
        rd(a_clm(0), 0, "R1 claim reset");
        chk_irq(0, 1'b0, "R1 irq0 reset");
        chk_irq(1, 1'b0, "R1 irq1 reset");

        // R2: priority field width and source-0 slot
        wr(a_prio(1), 32'hFF);
        rd(a_prio(1), 7, "R2 prio 3-bit");
        wr(a_prio(0), 32'h5);
        rd(a_prio(0), 0, "R2 offset 0 reads zero");
        wr(a_prio(1), 0);

        // R3: enable word, bit 0 not settable
        wr(a_en(0), 32'hFFFF_FFFF);
        rd(a_en(0), 32'hFFFF_FFFE, "R3 enable bit0 zero");

        // R4: threshold width and location
        wr(a_thr(0), 9);
        rd(a_thr(0), 1, "R4 threshold 3-bit");
        wr(a_thr(0), 1);

        // R5/R6: priorities and tie-break
        wr(a_prio(3), 2);
        wr(a_prio(5), 2);
        wr(a_prio(7), 5);
        src_irq[3] = 1'b1; src_irq[5] = 1'b1;
        tick();
        chk_irq(0, 1'b1, "R5 irq above threshold");
        wr(a_thr(0), 2);
        chk_irq(0, 1'b0, "R5 equal to threshold masks");
        wr(a_thr(0), 1);
        chk_irq(0, 1'b1, "R5 irq restored");
        rd(a_clm(0), 3, "R6 tie smaller id");
        rd(a_clm(0), 5, "R6 next claim");
        rd(a_clm(0), 0, "R6 empty claim");
        chk_irq(0, 1'b0, "R7 irq low after claims");

        // R7: line still high, but held off
        tick();
        rd(a_clm(0), 0, "R7 gateway held");

        // R9: ignored completions
        wr(a_clm(0), 0);
        wr(a_clm(0), 40);
        wr(a_clm(1), 3);
        tick();
        rd(a_clm(0), 0, "R9 bad completions ignored");

        // R8: valid completion re-arms
        wr(a_clm(0), 3);
        rd(a_clm(0), 3, "R8 re-pend after complete");

        // R6: highest priority wins
        src_irq[7] = 1'b1;
        wr(a_clm(0), 5);
        tick();
        rd(a_clm(0), 7, "R6 highest priority");
        rd(a_clm(0), 5, "R6 then lower priority");

        // R5: priority 0 never raises
        src_irq[9] = 1'b1;
        tick();
        chk_irq(0, 1'b0, "R5 priority 0 silent");

        // R10: unmapped space
        wr(AW'(32'h1000), 32'h7);
        rd(AW'(32'h1000), 0, "R10 unmapped read zero");
        rd(AW'(32'h2004), 0, "R10 enable word 1 zero");
        rd(a_prio(1), 0, "R10 write had no effect");

        // R11: two contexts share a source
        wr(a_en(1), 32'h200);
        wr(a_prio(9), 4);
        chk_irq(0, 1'b1, "R11 ctx0 sees source 9");
        chk_irq(1, 1'b1, "R11 ctx1 sees source 9");
        rd(a_clm(1), 9, "R11 ctx1 claims");
        chk_irq(0, 1'b0, "R11 ctx0 cleared by other claim");
        chk_irq(1, 1'b0, "R11 ctx1 cleared");

        repeat (2) tick();
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending items", sb.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule